// File: doc/BRIEF.md
# I2C Block-Transfer Configuration Target

This block is an I2C target that holds a small bank of clock-configuration bytes. The clock-control logic reads them on a parallel bus. A host updates the bank with block writes. Each write carries a command byte and a count byte, both acknowledged and then thrown away, followed by data bytes. The data bytes fill the bank in order, starting at byte 0. A host reads the bank back with block reads. The block first returns a byte count, then every configuration byte, then one read-only status byte taken from the `status_i` input (for example latched strap pins). There is no register pointer: every transfer starts at byte 0.

SCL and SDA are oversampled by the fast system clock through two-flop synchronisers. START and STOP are taken only from SDA edges while SCL is high. The block answers only the 8-bit addresses 0xD2 (write) and 0xD3 (read). It pulls SDA low through an open-drain enable, both to acknowledge and to send read data. Bytes travel MSB first at standard-mode rates. The system clock must run well above the SCL rate: at least eight system clocks per SCL half period.

Top module: `cfgbus_i2c_target`

## Requirements
- R1: After reset, configuration byte 0 is 0x00, bytes 1 to 5 are 0xFF, and `sda_oe` is 0. Byte k appears on `cfg_o[8k+7:8k]`.
- R2: The block acknowledges an address byte (pulls SDA low during the ninth SCL pulse) only for 0xD2 and 0xD3. Any other address gets no acknowledge and leaves the configuration unchanged.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. Each later byte is acknowledged and stored in byte 0, 1, 2 and so on, in that order.
- R4: A STOP after any complete byte ends the write. Bytes not yet reached keep their previous values.
- R5: Data bytes past the sixth, including the one aimed at the read-only status position, are acknowledged but change nothing.
- R6: A read returns 7 (the number of bytes that follow), then configuration bytes 0 to 5, then `status_i`, then 0xFF for every byte after that. Each byte is sent MSB first.
- R7: A host NACK after a read byte ends the transfer. SDA stays released for any further SCL pulses until the next START.
- R8: A repeated START abandons the current transfer, and the byte after it is decoded as a fresh address.
- R9: SDA changes while SCL is low are data, not START or STOP, and do not disturb a transfer.
- R10: `sda_oe` rises only while SCL is low, so SDA is never pulled low during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| status_i | input | 8 | Read-only status byte returned after the configuration bytes |
| cfg_o | output | 48 | Configuration bytes; byte k on bits 8k+7 to 8k |

## Verification
Every bus event reaches the state machine two system clocks after it appears at the pins, and the registered response takes one more clock. An acknowledge or read bit on `sda_oe`, and a stored byte on `cfg_o`, therefore change three clocks after the SCL falling edge that triggers them. The bench holds each quarter of an SCL bit for four clocks. It drives SDA only at the midpoint of the SCL low phase and samples SDA one quarter into the SCL high phase, so every device response is settled before it is read. `cfg_o` is compared only after the STOP sequence, several quarters after the last write could have landed.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_CNT,
    PH_DATA
  } wr_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe;
  logic [MSB:0] sda_pipe;
  logic         scl_q;
  logic         sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
      scl_q    <= scl_pipe[MSB];
      sda_q    <= sda_pipe[MSB];
    end
  end

  assign scl_s     = scl_pipe[MSB];
  assign sda_s     = sda_pipe[MSB];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall})); // R9
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int NUM_CFG = 6,
  parameter int IDXW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IDXW-1:0]      rd_idx,
  input  logic [7:0]           status_i,
  output logic [7:0]           rd_data,
  output logic [NUM_CFG*8-1:0] cfg_o
);
  localparam int READ_LEN = NUM_CFG + 1;

  logic [7:0] cfg_q [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_byte
    localparam logic [7:0] DEFAULT = (i == 0) ? 8'h00 : 8'hFF;
    logic load;
    assign load = wr_en && (wr_idx == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= DEFAULT;
      end else if (load) begin
        cfg_q[i] <= wr_data;
      end
    end

    assign cfg_o[i*8 +: 8] = cfg_q[i];
  end

  always_comb begin
    rd_data = 8'hFF;
    if (rd_idx == '0) begin
      rd_data = 8'(READ_LEN);
    end else if (rd_idx == IDXW'(NUM_CFG + 1)) begin
      rd_data = status_i;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (rd_idx == IDXW'(i + 1)) rd_data = cfg_q[i];
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDXW'(NUM_CFG))); // R5
endmodule

// File: rtl/i2c_block_fsm.sv
module i2c_block_fsm
  import cfgbus_pkg::*;
#(
  parameter int         NUM_CFG = 6,
  parameter int         IDXW    = 4,
  parameter logic [7:0] ADDR_WR = 8'hD2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic [7:0]      rd_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            sda_oe
);
  localparam logic [IDXW-1:0] WIDX_MAX = IDXW'(NUM_CFG);
  localparam logic [IDXW-1:0] RIDX_MAX = IDXW'(NUM_CFG + 2);

  tgt_state_e      state_q, state_d;
  wr_phase_e       phase_q, phase_d;
  logic [3:0]      cnt_q, cnt_d;
  logic [7:0]      sh_q, sh_d;
  logic [IDXW-1:0] widx_q, widx_d;
  logic [IDXW-1:0] ridx_q, ridx_d;
  logic            hack_q, hack_d;
  logic            oe_q, oe_d;
  logic            addr_hit;

  assign addr_hit = (sh_q[7:1] == ADDR_WR[7:1]);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    widx_d  = widx_q;
    ridx_d  = ridx_q;
    hack_d  = hack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (stop_evt) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      ridx_d  = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (addr_hit) begin
              oe_d    = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            phase_d = PH_CMD;
            widx_d  = '0;
            if (sh_q[0]) begin
              sh_d    = rd_data;
              oe_d    = ~rd_data[7];
              ridx_d  = ridx_q + 1'b1;
              state_d = ST_RD_BYTE;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            oe_d    = 1'b1;
            state_d = ST_WR_ACK;
            unique case (phase_q)
              PH_CMD:  phase_d = PH_CNT;
              PH_CNT:  phase_d = PH_DATA;
              default: begin
                wr_en = (widx_q < WIDX_MAX);
                if (widx_q != WIDX_MAX) widx_d = widx_q + 1'b1;
              end
            endcase
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise && cnt_q < 4'd8) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else if (cnt_q != 4'd0) begin
              sh_d = {sh_q[6:0], 1'b1};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              sh_d    = rd_data;
              oe_d    = ~rd_data[7];
              cnt_d   = '0;
              state_d = ST_RD_BYTE;
              if (ridx_q != RIDX_MAX) ridx_d = ridx_q + 1'b1;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      widx_q  <= '0;
      ridx_q  <= '0;
      hack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      widx_q  <= widx_d;
      ridx_q  <= ridx_d;
      hack_q  <= hack_d;
      oe_q    <= oe_d;
    end
  end

  assign wr_idx  = widx_q;
  assign wr_data = sh_q;
  assign rd_idx  = ridx_q;
  assign sda_oe  = oe_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q); // R7
  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && scl_fall && !hack_q && !start_evt && !stop_evt) |=> (state_q == ST_IDLE)); // R7
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR && !oe_q && cnt_q == 4'd0)); // R8
  AST_ACK_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> (sh_q[7:1] == ADDR_WR[7:1])); // R2
  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8); // R3
endmodule

// File: rtl/cfgbus_i2c_target.sv
module cfgbus_i2c_target #(
  parameter int         NUM_CFG     = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ADDR_WR     = 8'hD2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [7:0]           status_i,
  output logic [NUM_CFG*8-1:0] cfg_o
);
  localparam int IDXW = $clog2(NUM_CFG + 3);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [7:0]      wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_block_fsm #(.NUM_CFG(NUM_CFG), .IDXW(IDXW), .ADDR_WR(ADDR_WR)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .sda_oe(sda_oe)
  );

  cfg_regbank #(.NUM_CFG(NUM_CFG), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .status_i(status_i),
    .rd_data(rd_data), .cfg_o(cfg_o)
  );
endmodule

// File: tb/tb_cfgbus_i2c_target.sv
module tb_cfgbus_i2c_target;
  localparam int Q = 4;
  localparam int NC = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          scl;
  logic          sda_h;
  logic [7:0]    status;
  logic          sda_oe;
  logic [NC*8-1:0] cfg;
  wire           sda_line = sda_h & ~sda_oe;

  cfgbus_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .status_i(status), .cfg_o(cfg)
  );

  int checks = 0;
  int fails = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [NC];

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (rst_n && sda_oe && !prev_oe && scl) oe_viol++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC*8-1:0] model_vec();
    logic [NC*8-1:0] v;
    for (int i = 0; i < NC; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b1; wq(Q);
  endtask

  task automatic wbit(input logic b, input logic wiggle);
    if (wiggle) begin
      sda_h = ~b; wq(1); sda_h = b; wq(1); sda_h = ~b; wq(1); sda_h = b; wq(Q - 3);
    end else begin
      sda_h = b; wq(Q);
    end
    scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, input logic wiggle, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(v[i], wiggle);
    rbit(x);
    ack = ~x;
  endtask

  task automatic rd_byte(input logic host_ack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      v[i] = x;
    end
    wbit(~host_ack, 1'b0);
  endtask

  // Block write: address, command, count, then n data bytes; returns acks missed.
  task automatic do_write(input int n, input logic [7:0] seed, input logic wiggle, output int misses);
    logic ack;
    logic [7:0] d;
    misses = 0;
    bus_start();
    wr_byte(8'hD2, 1'b0, ack); if (!ack) misses++;
    wr_byte(8'hAA, 1'b0, ack); if (!ack) misses++;
    wr_byte(8'h55, 1'b0, ack); if (!ack) misses++;
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 37);
      wr_byte(d, wiggle, ack); if (!ack) misses++;
      if (k < NC) model[k] = d;
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    int miss;
    rst_n = 1'b0; scl = 1'b1; sda_h = 1'b1; status = 8'h5A;
    for (int i = 0; i < NC; i++) model[i] = (i == 0) ? 8'h00 : 8'hFF;
    wq(5); rst_n = 1'b1; wq(6);

    // R1: reset state
    chk("R1 cfg", 64'(cfg), 64'(model_vec()));
    chk("R1 oe", 64'(sda_oe), 64'd0);

    // R2: sweep every address byte
    for (int a = 0; a < 256; a++) begin
      bus_start();
      wr_byte(8'(a), 1'b0, ack);
      chk("R2 ack", 64'(ack), 64'(a == 8'hD2 || a == 8'hD3));
      if (ack && a[0]) rd_byte(1'b0, v);
      bus_stop();
    end
    chk("R2 cfg unchanged", 64'(cfg), 64'(model_vec()));

    // R3 / R4: writes of every length 0..6 with different seeds
    for (int n = 0; n <= NC; n++) begin
      do_write(n, 8'(8'h10 + n * 8'h21), 1'b0, miss);
      chk(n == NC ? "R3 acks" : "R4 acks", 64'(miss), 64'd0);
      chk(n == NC ? "R3 cfg" : "R4 cfg", 64'(cfg), 64'(model_vec()));
    end

    // R5: overlong write, extra bytes acked but ignored
    do_write(NC + 3, 8'hC3, 1'b0, miss);
    chk("R5 acks", 64'(miss), 64'd0);
    chk("R5 cfg", 64'(cfg), 64'(model_vec()));

    // R6: full read
    status = 8'hA6;
    bus_start();
    wr_byte(8'hD3, 1'b0, ack);
    chk("R6 addr ack", 64'(ack), 64'd1);
    rd_byte(1'b1, v); chk("R6 count", 64'(v), 64'd7);
    for (int i = 0; i < NC; i++) begin
      rd_byte(1'b1, v); chk("R6 byte", 64'(v), 64'(model[i]));
    end
    rd_byte(1'b1, v); chk("R6 status", 64'(v), 64'hA6);
    rd_byte(1'b0, v); chk("R6 beyond", 64'(v), 64'hFF);
    bus_stop();

    // R7: NACK mid-read, further clocks see a released line
    bus_start();
    wr_byte(8'hD3, 1'b0, ack);
    rd_byte(1'b1, v);
    rd_byte(1'b0, v); chk("R7 byte0", 64'(v), 64'(model[0]));
    rd_byte(1'b0, v); chk("R7 released", 64'(v), 64'hFF);
    chk("R7 oe", 64'(sda_oe), 64'd0);
    bus_stop();

    // R8: repeated start between a write and a read
    bus_start();
    wr_byte(8'hD2, 1'b0, ack);
    wr_byte(8'h01, 1'b0, ack);
    wr_byte(8'h02, 1'b0, ack);
    wr_byte(8'h3C, 1'b0, ack); model[0] = 8'h3C;
    bus_start();
    wr_byte(8'hD3, 1'b0, ack);
    chk("R8 readdr ack", 64'(ack), 64'd1);
    rd_byte(1'b1, v); chk("R8 count", 64'(v), 64'd7);
    rd_byte(1'b0, v); chk("R8 byte0", 64'(v), 64'h3C);
    bus_stop();
    chk("R8 cfg", 64'(cfg), 64'(model_vec()));

    // R9: SDA wiggles while SCL is low
    do_write(NC, 8'h9E, 1'b1, miss);
    chk("R9 acks", 64'(miss), 64'd0);
    chk("R9 cfg", 64'(cfg), 64'(model_vec()));

    // R10: no SDA pull-down began while SCL was high
    chk("R10 oe timing", 64'(oe_viol), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule